// File: doc/BRIEF.md
# Second-Order Sigma-Delta Bitstream Modulator

This block turns a stream of signed multi-bit samples, arriving at the oversampled rate, into a one-bit stream. The ones density of that stream follows the input, so a one-bit DAC and an analog low-pass filter can rebuild the signal. Each accepted sample moves the loop forward by exactly one step and produces exactly one output bit. The loop runs two cascaded integrators. The first adds its input to its state and passes the result straight on. The second is registered. The quantiser reads the second integrator. Both integrators subtract the quantiser decision, fed back as plus or minus full scale. This gives a one-sample signal delay and a squared first-difference shaping of the quantisation noise. A parameter reduces the loop to a single registered integrator for first-order comparison.

Both sides of the block are valid/ready streams. A sample is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. A bit presented on `out_bit` with `out_valid` high stays unchanged until `out_ready` takes it. When `in_valid` is low the loop does not advance, so gaps in the input stream do not change the bit sequence.

Top module: `sigma_delta_mod2`

## Requirements
- R1: A synchronous reset clears both integrator states and the output register. While the reset is held, `out_valid` is 0 and `in_ready` is 1.
- R2: A sample is taken only when `in_valid` and `in_ready` are both 1, and `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_valid` hold. Gaps on either side do not change the bit sequence.
- R3: The integrator accumulators are W+GUARD bits wide and clamp at the signed limits of that width instead of wrapping. With a positive state and a non-negative increment the state never decreases, and the mirror rule holds for negative values.
- R4: The quantiser emits 1 when the integrator it reads is greater than or equal to zero. Bit 1 feeds back +FS and bit 0 feeds back −FS, where FS = 2^(W−1)−1.
- R5: With ORDER=2, after reset and with zero input, the bit sequence is 1,0,0,1 repeating.
- R6: With ORDER=1, after reset and with zero input, the bit sequence is 1,0 repeating.
- R7: For a constant input x with |x| ≤ FS/2, after 64 settling samples, the ones count over 4096 samples equals 4096·(FS+x)/(2·FS) within 1% of 4096. This holds for both orders.
- R8: The first bit after reset is 1 whatever the first sample is. The first sample first shows in the second bit: a first sample of −FS makes the second bit 0 in both orders.
- R9: An input at the most negative code, below −FS, held for 4096 samples gives a ones density of no more than 1%. After that, a zero input brings the density back to one half within 1%.
- R10: ORDER=2 builds the non-registered plus registered integrator pair. Any other value builds a single registered integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the oversampled rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | W | Signed two's-complement sample |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Consumer takes the bit this cycle |
| out_bit | output | 1 | Modulated one-bit stream |

## Verification
The bench starts from reset with a zero input and checks the exact 1,0,0,1 and 1,0 sequences. During that run it inserts gaps and stalls on both sides. A design that advanced the loop without a handshake, or dropped a bit on a stall, would break the pattern. The bench then sweeps constant inputs across ±FS/2 on both orders and compares the ones count with the ratio computed arithmetically. A wrong feedback sign or a wrong comparator threshold would shift or invert the density. Finally the bench drives an input beyond full scale and then returns to zero. Accumulators that wrapped instead of clamping would show ones during the overload and would recover with a wrong density.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  // Accumulator width: input width plus headroom bits.
  function automatic int acc_bits(input int in_bits, input int guard);
    return in_bits + guard;
  endfunction
endpackage

// File: rtl/sdm_integrator.sv
module sdm_integrator #(
  parameter int AW      = 20,
  parameter int DW      = 21,
  parameter bit DELAYED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [AW-1:0] acc_o
);
  localparam int SW = ((AW > DW) ? AW : DW) + 1;
  localparam logic signed [AW-1:0] HI_A = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO_A = {1'b1, {(AW-1){1'b0}}};
  localparam logic signed [SW-1:0] HI_S = {{(SW-AW){1'b0}}, HI_A};
  localparam logic signed [SW-1:0] LO_S = {{(SW-AW){1'b1}}, LO_A};

  logic signed [AW-1:0] acc_q;
  logic signed [SW-1:0] sum;
  logic signed [AW-1:0] nxt;

  assign sum = SW'(acc_q) + SW'(din);

  always_comb begin
    if (sum > HI_S)      nxt = HI_A;
    else if (sum < LO_S) nxt = LO_A;
    else                 nxt = sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= nxt;
  end

  generate
    if (DELAYED) begin : g_reg_out
      assign acc_o = acc_q;
    end else begin : g_pass_out
      assign acc_o = nxt;
    end
  endgenerate

  // R3: clamping, never wrapping
  p_no_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
    (en && acc_q > 0 && din >= 0) |=> (acc_q >= $past(acc_q)));
  p_no_wrap_dn_r3: assert property (@(posedge clk) disable iff (rst)
    (en && acc_q < 0 && din <= 0) |=> (acc_q <= $past(acc_q)));
  // R1: cleared by reset
  p_clear_r1: assert property (@(posedge clk) rst |=> (acc_q == '0));
endmodule

// File: rtl/sdm_quantizer.sv
module sdm_quantizer #(
  parameter int W  = 16,
  parameter int AW = 20,
  parameter int FW = 21
) (
  input  logic signed [AW-1:0] level,
  output logic                 bit_o,
  output logic signed [FW-1:0] fb
);
  localparam logic signed [FW-1:0] FS_F = FW'({1'b0, {(W-1){1'b1}}});

  assign bit_o = ~level[AW-1];
  assign fb    = bit_o ? FS_F : -FS_F;

  // R4: the decision follows the sign of the integrator it reads
  always_comb begin
    if (level >= 0) a_decide_pos_r4: assert (bit_o == 1'b1 || $isunknown(level));
  end
endmodule

// File: rtl/sigma_delta_mod2.sv
module sigma_delta_mod2 #(
  parameter int W     = 16,
  parameter int GUARD = 4,
  parameter int ORDER = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bit
);
  localparam int AW = sdm_pkg::acc_bits(W, GUARD);
  localparam int DW = AW + 1;

  logic                 accept;
  logic                 qbit;
  logic signed [DW-1:0] fb;
  logic signed [DW-1:0] x_ext;
  logic signed [AW-1:0] q_level;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign x_ext    = DW'(in_data);

  generate
    if (ORDER == 2) begin : g_second
      logic signed [AW-1:0] w1;
      logic signed [DW-1:0] d1, d2;
      assign d1 = x_ext - fb;
      sdm_integrator #(.AW(AW), .DW(DW), .DELAYED(1'b0)) u_int1 (
        .clk(clk), .rst(rst), .en(accept), .din(d1), .acc_o(w1));
      assign d2 = DW'(w1) - fb;
      sdm_integrator #(.AW(AW), .DW(DW), .DELAYED(1'b1)) u_int2 (
        .clk(clk), .rst(rst), .en(accept), .din(d2), .acc_o(q_level));
    end else begin : g_first
      logic signed [DW-1:0] d1;
      assign d1 = x_ext - fb;
      sdm_integrator #(.AW(AW), .DW(DW), .DELAYED(1'b1)) u_int1 (
        .clk(clk), .rst(rst), .en(accept), .din(d1), .acc_o(q_level));
    end
  endgenerate

  sdm_quantizer #(.W(W), .AW(AW), .FW(DW)) u_quant (
    .level(q_level), .bit_o(qbit), .fb(fb));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_bit   <= qbit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: back-pressure closes the input and freezes the output
  p_stall_closes_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  p_stall_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  // R1: reset empties the output register
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/sim_sigma_delta_mod2.sv
module sim_sigma_delta_mod2;
  localparam int W  = 16;
  localparam int FS = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, in_valid, out_ready;
  logic signed [W-1:0] in_data;
  logic in_ready0, out_valid0, out_bit0;
  logic in_ready1, out_valid1, out_bit1;

  sigma_delta_mod2 #(.W(W), .GUARD(4), .ORDER(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready0),
    .in_data(in_data), .out_valid(out_valid0), .out_ready(out_ready), .out_bit(out_bit0));
  sigma_delta_mod2 #(.W(W), .GUARD(4), .ORDER(1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready1),
    .in_data(in_data), .out_valid(out_valid1), .out_ready(out_ready), .out_bit(out_bit1));

  int checks = 0, fails = 0;
  bit done = 0;
  longint ones0 = 0, tot0 = 0, ones1 = 0, tot1 = 0;
  bit log_en = 0;
  int lidx0 = 0, lidx1 = 0;
  bit log0 [8];
  bit log1 [8];

  always @(negedge clk) begin
    if (!rst && out_ready) begin
      if (out_valid0) begin
        tot0++; ones0 += out_bit0;
        if (log_en && lidx0 < 8) begin log0[lidx0] = out_bit0; lidx0++; end
      end
      if (out_valid1) begin
        tot1++; ones1 += out_bit1;
        if (log_en && lidx1 < 8) begin log1[lidx1] = out_bit1; lidx1++; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Ones count over n samples against (FS+x)/(2FS), tolerance 1% of n (R7, R9)
  task automatic density(input int x, input int settle, input int n, input string req);
    longint b0, b1, t0, t1, o0, o1, c0, c1;
    in_data = W'(x); in_valid = 1; out_ready = 1;
    repeat (settle) step();
    b0 = ones0; b1 = ones1; t0 = tot0; t1 = tot1;
    repeat (n) step();
    o0 = ones0 - b0; o1 = ones1 - b1; c0 = tot0 - t0; c1 = tot1 - t1;
    check(c0 == n && c1 == n, {req, " sample count"}, c0, n);
    check((o0 * 2 * FS - c0 * (FS + x)) * 100 <= c0 * 2 * FS &&
          (c0 * (FS + x) - o0 * 2 * FS) * 100 <= c0 * 2 * FS,
          {req, " order2 density"}, o0, (c0 * (FS + x)) / (2 * FS));
    check((o1 * 2 * FS - c1 * (FS + x)) * 100 <= c1 * 2 * FS &&
          (c1 * (FS + x) - o1 * 2 * FS) * 100 <= c1 * 2 * FS,
          {req, " order1 density"}, o1, (c1 * (FS + x)) / (2 * FS));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic hold;
    int lv [9] = '{0, 16383, -16383, 8191, -8191, 3277, -1000, 12345, -12000};
    rst = 1; in_valid = 0; in_data = '0; out_ready = 1;
    repeat (3) step();
    // R1: reset state
    check(!out_valid0 && !out_valid1, "R1 out_valid in reset", out_valid0, 0);
    check(in_ready0 && in_ready1, "R1 in_ready in reset", in_ready0, 1);

    // R5, R6, R2: zero input with gaps and stalls
    log_en = 1; rst = 0;
    for (int i = 0; i < 12; i++) begin
      in_valid = (i % 3) != 1;
      out_ready = (i % 4) != 2;
      step();
    end
    in_valid = 1; out_ready = 0; step();
    hold = out_bit0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(out_valid0 && !in_ready0 && out_bit0 == hold, "R2 stall holds", out_bit0, hold);
    end
    out_ready = 1;
    for (int i = 0; i < 20 && (lidx0 < 8 || lidx1 < 8); i++) step();
    in_valid = 0; step();
    log_en = 0;
    for (int k = 0; k < 8; k++) begin
      check(log0[k] == ((k % 4 == 0) || (k % 4 == 3)), "R5 order2 zero pattern", log0[k],
            (k % 4 == 0) || (k % 4 == 3));
      check(log1[k] == (k % 2 == 0), "R6 order1 zero pattern", log1[k], k % 2 == 0);
    end

    // R8, R4: one-sample delay; first sample -FS
    rst = 1; repeat (2) step(); rst = 0;
    in_data = W'(-FS); in_valid = 1; out_ready = 1;
    step();
    check(out_bit0 && out_bit1, "R8 first bit is 1", out_bit0, 1);
    step();
    check(!out_bit0 && !out_bit1, "R8 R4 second bit follows -FS", out_bit0, 0);

    // R7, R10: DC sweep on both orders
    foreach (lv[k]) density(lv[k], 64, 4096, "R7");

    // R9, R3: overload below -FS, then recovery
    begin
      longint b0, b1;
      in_data = {1'b1, {(W-1){1'b0}}}; in_valid = 1;
      repeat (16) step();
      b0 = ones0; b1 = ones1;
      repeat (4096) step();
      check((ones0 - b0) * 100 <= 4096, "R9 R3 overload order2", ones0 - b0, 0);
      check((ones1 - b1) * 100 <= 4096, "R9 R3 overload order1", ones1 - b1, 0);
    end
    density(0, 256, 4096, "R9 recovery");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule